// File: doc/BRIEF.md
# Spread Spectrum Modulation Profile Generator

This block produces a frequency-offset word that a downstream fractional divider or digitally controlled oscillator adds to its nominal setting. Sweeping that offset back and forth spreads the energy of the output clock across a band. The offset is a signed value in units of 0.01 % of nominal frequency. It follows a symmetric triangle whose step rate comes from a programmable tick divider. The user picks that divider so that one full sweep repeats at 20 kHz to 40 kHz.

A 5-bit selection code picks the profile type and its amplitude from a constant table inside the block. In a down profile the offset stays between zero and minus the amplitude, so the clock never runs above nominal. In a center profile it swings equally above and below nominal. The code is held in a small configuration register. The two upper code bits can instead come from strap pins. A new selection takes effect only when the sweep passes through zero, so the frequency never jumps. When spread is disabled the offset is held at exactly zero.

Top module: `ssc_profile_gen`

## Requirements
- R1: After reset the offset is 0 and the configuration register holds code 1, which selects a 0.80 % down profile (amplitude 80).
- R2: While spread_en is low, the offset is 0 from the first clock edge at which the low level is sampled, and it stays 0.
- R3: The offset changes only on divider ticks, which come once every tick_div+1 clocks. Every tick moves the offset by exactly one unit.
- R4: In a down profile of amplitude A, the offset starts by stepping down from 0 and stays within [-A, 0]. It traces a triangle of 2A ticks, with k ticks after enable giving -p for p = k mod 2A when p <= A, and -(2A-p) otherwise.
- R5: In a center profile of amplitude A, the offset starts by stepping up from 0 after enable and stays within [-A, +A]. It traces a triangle of 4A ticks: p for p <= A, 2A-p for p <= 3A, and p-4A otherwise, where p = k mod 4A.
- R6: The code table, with amplitudes in 0.01 % units, is as follows. Codes 0-5 are down 60, 80, 100, 125, 150, 200. Codes 6 and 7 are center 50 and 100. Codes 8-15 are down 60, 80, 100, 125, 150, 175, 200, 250. Code 16 is down 300. Codes 17-23 are center 30, 40, 50, 70, 100, 120, 150. Codes 24-31 repeat codes 0-7.
- R7: When src_sw is 1, the code comes entirely from the register and fs_pins is ignored. When src_sw is 0, code bits 4:3 are fs_pins[1:0] and code bits 2:0 come from the register.
- R8: A code written while the sweep is away from zero leaves the running excursion unchanged. The new profile starts at the next tick on which the offset is 0.
- R9: The offset is a 16-bit two's-complement word, so one unit below nominal reads 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spread_en | input | 1 | 1 enables modulation; 0 forces the offset to zero |
| src_sw | input | 1 | 1 takes the code from the register; 0 takes the upper bits from the pins |
| fs_pins | input | 2 | Strap inputs for code bits 4:3 |
| cfg_we | input | 1 | Write strobe for the configuration register |
| cfg_code | input | 5 | Code written when cfg_we is high |
| tick_div | input | 16 | Divider setting; one tick every tick_div+1 clocks |
| offset | output | 16 | Signed frequency offset in 0.01 % units |

## Verification
The hardest case to reach is a selection change in the middle of an excursion. The write has to land while the offset is far from zero, and the check is that the old amplitude is kept until the sweep returns to zero and that the new amplitude then takes over with no step. The bench enables a 0.80 % down sweep with one tick per clock. It writes a 2.00 % code exactly 40 ticks in, then compares every following sample against a piecewise trajectory: the old triangle up to its zero, then the new triangle counted from that zero. A second hard case is tick alignment when the divider phase is unknown. It is handled by counting offset changes over a window that is a whole multiple of the divider period.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

   localparam int AMP_W = 9;

   typedef enum logic {DIR_UP = 1'b0, DIR_DN = 1'b1} ssc_dir_t;

   typedef struct packed {
      logic             center;
      logic [AMP_W-1:0] amp;
   } ssc_prof_t;

   function automatic ssc_prof_t ssc_mk(input logic center, input int unsigned amp);
      ssc_prof_t p;
      p.center = center;
      p.amp    = AMP_W'(amp);
      return p;
   endfunction

   // Amplitudes are in 0.01 % units of nominal frequency.
   function automatic ssc_prof_t ssc_decode(input logic [4:0] code);
      ssc_prof_t p;
      unique case (code[4:3])
         2'd1: begin
            unique case (code[2:0])
               3'd0: p = ssc_mk(1'b0, 60);
               3'd1: p = ssc_mk(1'b0, 80);
               3'd2: p = ssc_mk(1'b0, 100);
               3'd3: p = ssc_mk(1'b0, 125);
               3'd4: p = ssc_mk(1'b0, 150);
               3'd5: p = ssc_mk(1'b0, 175);
               3'd6: p = ssc_mk(1'b0, 200);
               default: p = ssc_mk(1'b0, 250);
            endcase
         end
         2'd2: begin
            unique case (code[2:0])
               3'd0: p = ssc_mk(1'b0, 300);
               3'd1: p = ssc_mk(1'b1, 30);
               3'd2: p = ssc_mk(1'b1, 40);
               3'd3: p = ssc_mk(1'b1, 50);
               3'd4: p = ssc_mk(1'b1, 70);
               3'd5: p = ssc_mk(1'b1, 100);
               3'd6: p = ssc_mk(1'b1, 120);
               default: p = ssc_mk(1'b1, 150);
            endcase
         end
         default: begin
            unique case (code[2:0])
               3'd0: p = ssc_mk(1'b0, 60);
               3'd1: p = ssc_mk(1'b0, 80);
               3'd2: p = ssc_mk(1'b0, 100);
               3'd3: p = ssc_mk(1'b0, 125);
               3'd4: p = ssc_mk(1'b0, 150);
               3'd5: p = ssc_mk(1'b0, 200);
               3'd6: p = ssc_mk(1'b1, 50);
               default: p = ssc_mk(1'b1, 100);
            endcase
         end
      endcase
      return p;
   endfunction

endpackage

// File: rtl/ssc_tick_div.sv
module ssc_tick_div #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o
);

   logic [DIV_W-1:0] cnt_q;

   // >= so that lowering div_i below the running count recovers at once
   assign tick_o = (cnt_q >= div_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (tick_o) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + DIV_W'(1);
      end
   end

endmodule

// File: rtl/ssc_code_sel.sv
module ssc_code_sel #(
   parameter int               CODE_W       = 5,
   parameter int               PIN_W        = 2,
   parameter logic [CODE_W-1:0] DEFAULT_CODE = CODE_W'(1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [CODE_W-1:0] wdata_i,
   input  logic              src_sw_i,
   input  logic [PIN_W-1:0]  pins_i,
   output logic [CODE_W-1:0] code_o
);

   localparam int PIN_LO = CODE_W - PIN_W;

   logic [CODE_W-1:0] reg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_q <= DEFAULT_CODE;
      end else if (we_i) begin
         reg_q <= wdata_i;
      end
   end

   for (genvar i = 0; i < CODE_W; i++) begin : g_bit
      if (i >= PIN_LO) begin : g_strap
         assign code_o[i] = src_sw_i ? reg_q[i] : pins_i[i-PIN_LO];
      end else begin : g_soft
         assign code_o[i] = reg_q[i];
      end
   end

endmodule

// File: rtl/ssc_tri_acc.sv
module ssc_tri_acc
   import ssc_pkg::*;
#(
   parameter int OFF_W = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en_i,
   input  logic                    tick_i,
   input  ssc_prof_t               prof_next_i,
   output logic signed [OFF_W-1:0] acc_o,
   output ssc_prof_t               prof_o
);

   localparam logic signed [OFF_W-1:0] ONE  = OFF_W'(1);
   localparam logic signed [OFF_W-1:0] ZERO = '0;

   logic signed [OFF_W-1:0] acc_q, acc_d, step, top, bot, amp_s;
   ssc_dir_t                dir_q, dir_d, dir_eff;
   ssc_prof_t               prof_q, prof_d, prof_use;
   logic                    at_zero, load;

   assign at_zero  = (acc_q == ZERO);
   assign load     = tick_i && at_zero;
   assign prof_use = load ? prof_next_i : prof_q;
   assign amp_s    = $signed({{(OFF_W-AMP_W){1'b0}}, prof_use.amp});
   assign top      = prof_use.center ? amp_s : ZERO;
   assign bot      = -amp_s;

   always_comb begin
      // a down profile leaving zero must head below nominal
      dir_eff = (at_zero && !prof_use.center) ? DIR_DN : dir_q;
      step    = (dir_eff == DIR_UP) ? acc_q + ONE : acc_q - ONE;
      acc_d   = acc_q;
      dir_d   = dir_q;
      prof_d  = prof_q;
      if (!en_i) begin
         acc_d  = ZERO;
         dir_d  = DIR_UP;
         prof_d = prof_next_i;
      end else if (tick_i) begin
         acc_d  = step;
         prof_d = prof_use;
         if (dir_eff == DIR_UP && step == top) begin
            dir_d = DIR_DN;
         end else if (dir_eff == DIR_DN && step == bot) begin
            dir_d = DIR_UP;
         end else begin
            dir_d = dir_eff;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= ZERO;
         dir_q  <= DIR_UP;
         prof_q <= ssc_decode(5'd1);
      end else begin
         acc_q  <= acc_d;
         dir_q  <= dir_d;
         prof_q <= prof_d;
      end
   end

   assign acc_o  = acc_q;
   assign prof_o = prof_q;

endmodule

// File: rtl/ssc_profile_gen.sv
module ssc_profile_gen
   import ssc_pkg::*;
#(
   parameter int OFF_W        = 16,
   parameter int DIV_W        = 16,
   parameter int CODE_W       = 5,
   parameter int PIN_W        = 2,
   parameter int DEFAULT_CODE = 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    spread_en,
   input  logic                    src_sw,
   input  logic [PIN_W-1:0]        fs_pins,
   input  logic                    cfg_we,
   input  logic [CODE_W-1:0]       cfg_code,
   input  logic [DIV_W-1:0]        tick_div,
   output logic signed [OFF_W-1:0] offset
);

   if (CODE_W != 5) begin : g_chk_code
      $error("ssc_profile_gen: CODE_W must be 5 to index the profile table");
   end
   if (PIN_W < 1 || PIN_W >= CODE_W) begin : g_chk_pin
      $error("ssc_profile_gen: PIN_W must be in 1..CODE_W-1");
   end
   if (OFF_W <= AMP_W + 1) begin : g_chk_off
      $error("ssc_profile_gen: OFF_W too narrow for the largest amplitude");
   end
   if (DIV_W < 1) begin : g_chk_div
      $error("ssc_profile_gen: DIV_W must be positive");
   end

   logic              tick_w;
   logic [CODE_W-1:0] code_w;
   ssc_prof_t         prof_next_w, prof_w;
   logic              prof_center_w;
   logic [AMP_W-1:0]  prof_amp_w;

   ssc_tick_div #(.DIV_W(DIV_W)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .div_i  (tick_div),
      .tick_o (tick_w)
   );

   ssc_code_sel #(
      .CODE_W       (CODE_W),
      .PIN_W        (PIN_W),
      .DEFAULT_CODE (CODE_W'(DEFAULT_CODE))
   ) u_sel (
      .clk      (clk),
      .rst_n    (rst_n),
      .we_i     (cfg_we),
      .wdata_i  (cfg_code),
      .src_sw_i (src_sw),
      .pins_i   (fs_pins),
      .code_o   (code_w)
   );

   assign prof_next_w = ssc_decode(code_w[4:0]);

   ssc_tri_acc #(.OFF_W(OFF_W)) u_acc (
      .clk         (clk),
      .rst_n       (rst_n),
      .en_i        (spread_en),
      .tick_i      (tick_w),
      .prof_next_i (prof_next_w),
      .acc_o       (offset),
      .prof_o      (prof_w)
   );

   assign prof_center_w = prof_w.center;
   assign prof_amp_w    = prof_w.amp;

endmodule

// File: rtl/ssc_profile_chk.sv
module ssc_profile_chk #(
   parameter int OFF_W = 16,
   parameter int AMP_W = 9
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    spread_en,
   input logic                    tick,
   input logic signed [OFF_W-1:0] offset,
   input logic                    prof_center,
   input logic [AMP_W-1:0]        prof_amp
);

   logic signed [OFF_W-1:0] amp_s;
   assign amp_s = $signed({{(OFF_W-AMP_W){1'b0}}, prof_amp});

   // R2: a sampled low enable leaves a zero offset
   a_r2_disabled_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !spread_en |=> (offset == '0));

   // R3: no movement without a tick
   a_r3_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
      (spread_en && !tick) |=> $stable(offset));

   // R3: each tick moves by exactly one unit
   a_r3_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
      (spread_en && tick) |=> (offset == $past(offset) + OFF_W'(1) ||
                               offset == $past(offset) - OFF_W'(1)));

   // R4: down profile never goes above nominal or below -A
   a_r4_down_range: assert property (@(posedge clk) disable iff (!rst_n)
      !prof_center |-> (offset <= 0 && offset >= -amp_s));

   // R5: center profile stays within +/-A
   a_r5_center_range: assert property (@(posedge clk) disable iff (!rst_n)
      prof_center |-> (offset <= amp_s && offset >= -amp_s));

   // R8: active profile switches only at a zero of the sweep
   a_r8_switch_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({prof_center, prof_amp}) |-> ($past(offset) == '0));

endmodule

bind ssc_profile_gen ssc_profile_chk #(.OFF_W(OFF_W), .AMP_W(ssc_pkg::AMP_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .spread_en   (spread_en),
   .tick        (tick_w),
   .offset      (offset),
   .prof_center (prof_center_w),
   .prof_amp    (prof_amp_w)
);

// File: tb/tb_ssc_profile_gen.sv
module tb_ssc_profile_gen;

   logic               clk = 1'b0;
   logic               rst_n;
   logic               spread_en;
   logic               src_sw;
   logic [1:0]         fs_pins;
   logic               cfg_we;
   logic [4:0]         cfg_code;
   logic [15:0]        tick_div;
   logic signed [15:0] offset;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   ssc_profile_gen dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .spread_en (spread_en),
      .src_sw    (src_sw),
      .fs_pins   (fs_pins),
      .cfg_we    (cfg_we),
      .cfg_code  (cfg_code),
      .tick_div  (tick_div),
      .offset    (offset)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int f_down(input int a, input int k);
      int p = k % (2 * a);
      return (p <= a) ? -p : -(2 * a - p);
   endfunction

   function automatic int f_ctr(input int a, input int k);
      int p = k % (4 * a);
      if (p <= a) return p;
      if (p <= 3 * a) return 2 * a - p;
      return p - 4 * a;
   endfunction

   task automatic write_code(input logic [4:0] c);
      @(negedge clk);
      cfg_code = c;
      cfg_we   = 1'b1;
      @(negedge clk);
      cfg_we   = 1'b0;
   endtask

   task automatic go_idle();
      @(negedge clk);
      spread_en = 1'b0;
      @(negedge clk);
   endtask

   // caller is at a negedge; enable is raised here, sample k after k edges
   task automatic run_traj(input bit ctr, input int a, input int n, input string req,
                           output int mx, output int mn);
      int bad_k = -1, bad_a = 0, bad_e = 0;
      mx = -100000;
      mn = 100000;
      spread_en = 1'b1;
      for (int k = 1; k <= n; k++) begin
         int e;
         @(negedge clk);
         e = ctr ? f_ctr(a, k) : f_down(a, k);
         if (int'(offset) > mx) mx = int'(offset);
         if (int'(offset) < mn) mn = int'(offset);
         if (bad_k < 0 && int'(offset) != e) begin
            bad_k = k;
            bad_a = int'(offset);
            bad_e = e;
         end
      end
      check(bad_k < 0, req, bad_a, bad_e);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      spread_en = 1'b0;
      src_sw = 1'b1;
      fs_pins = 2'b00;
      cfg_we = 1'b0;
      cfg_code = 5'd0;
      tick_div = 16'd0;
      repeat (3) @(negedge clk);
      check(offset == 16'sd0, "R1 offset during reset", int'(offset), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(offset == 16'sd0, "R1 offset after reset", int'(offset), 0);
   endtask

   // R1 default profile, R4 down shape, R9 encoding
   task automatic t_down_default();
      int mx, mn;
      spread_en = 1'b1;
      @(negedge clk);
      check(offset == 16'hFFFF, "R9 first step encoding", int'(offset), -1);
      go_idle();
      run_traj(1'b0, 80, 320, "R1 R4 default 0.80 down trajectory", mx, mn);
      check(mn == -80, "R4 down minimum", mn, -80);
      check(mx == 0, "R4 down maximum", mx, 0);
   endtask

   task automatic t_disable();
      int nz = 0;
      @(negedge clk);
      spread_en = 1'b1;
      repeat (30) @(negedge clk);
      spread_en = 1'b0;
      @(negedge clk);
      check(offset == 16'sd0, "R2 zero one edge after disable", int'(offset), 0);
      repeat (20) begin
         @(negedge clk);
         if (offset != 16'sd0) nz++;
      end
      check(nz == 0, "R2 held at zero while disabled", nz, 0);
   endtask

   task automatic t_center();
      int mx, mn;
      write_code(5'd7);
      run_traj(1'b1, 100, 800, "R5 center 1.00 trajectory", mx, mn);
      check(mx == 100 && mn == -100, "R5 center extremes", mx, 100);
      go_idle();
   endtask

   task automatic t_divider();
      int changes = 0, bigstep = 0;
      logic signed [15:0] prev;
      write_code(5'd17);
      tick_div = 16'd3;
      @(negedge clk);
      spread_en = 1'b1;
      repeat (8) @(negedge clk);
      prev = offset;
      repeat (400) begin
         @(negedge clk);
         if (offset != prev) changes++;
         if (int'(offset) - int'(prev) > 1 || int'(prev) - int'(offset) > 1) bigstep++;
         prev = offset;
      end
      check(changes == 100, "R3 ticks per 400 clocks at divide 4", changes, 100);
      check(bigstep == 0, "R3 unit step size", bigstep, 0);
      tick_div = 16'd0;
      go_idle();
   endtask

   task automatic t_table();
      int mx, mn;
      int codes[6] = '{0, 5, 15, 16, 23, 30};
      int amps[6]  = '{60, 200, 250, 300, 150, 50};
      bit ctrs[6]  = '{0, 0, 0, 0, 1, 1};
      foreach (codes[i]) begin
         int per = ctrs[i] ? 4 * amps[i] : 2 * amps[i];
         write_code(5'(codes[i]));
         run_traj(ctrs[i], amps[i], per, $sformatf("R6 code %0d trajectory", codes[i]), mx, mn);
         check(mn == -amps[i], $sformatf("R6 code %0d minimum", codes[i]), mn, -amps[i]);
         go_idle();
      end
   endtask

   task automatic t_source();
      int mx, mn;
      write_code(5'd0);
      src_sw = 1'b0;
      fs_pins = 2'b10;
      @(negedge clk);
      run_traj(1'b0, 300, 600, "R7 pins select code 16", mx, mn);
      check(mn == -300, "R7 pin-selected amplitude", mn, -300);
      go_idle();
      src_sw = 1'b1;
      fs_pins = 2'b11;
      @(negedge clk);
      run_traj(1'b0, 60, 240, "R7 pins ignored in register mode", mx, mn);
      check(mn == -60, "R7 register-selected amplitude", mn, -60);
      go_idle();
   endtask

   task automatic t_zero_change();
      int bad_k = -1, bad_a = 0, bad_e = 0, mn = 0;
      write_code(5'd1);
      spread_en = 1'b1;
      for (int k = 1; k <= 560; k++) begin
         int e;
         @(negedge clk);
         if (k == 40) begin
            cfg_code = 5'd5;
            cfg_we = 1'b1;
         end
         if (k == 41) cfg_we = 1'b0;
         e = (k <= 160) ? f_down(80, k) : f_down(200, k - 160);
         if (k <= 160 && int'(offset) < mn) mn = int'(offset);
         if (bad_k < 0 && int'(offset) != e) begin
            bad_k = k;
            bad_a = int'(offset);
            bad_e = e;
         end
      end
      check(mn == -80, "R8 running excursion keeps old amplitude", mn, -80);
      check(bad_k < 0, "R8 new profile starts at zero", bad_a, bad_e);
      go_idle();
   endtask

   initial begin
      t_reset();
      t_down_default();
      t_disable();
      t_center();
      t_divider();
      t_table();
      t_source();
      t_zero_change();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(4 * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule